// File: doc/BRIEF.md
# Service Request Status Byte

This block builds an 8-bit status byte from summary flags supplied by upstream event logic and keeps a host-written enable mask that decides which of those flags count toward a master summary bit. The master summary is live: it follows the enabled flags in the same cycle. A separate request-for-service flag is latched when the summary rises. It drives the service request line and stays set until a serial poll is served.

The host has four operations. It can write the enable mask, read the mask back, or read the status byte directly, with no side effect. It can also serve a serial poll. A poll returns the byte with the latched request in bit 6 and then clears the request. A direct read puts the live summary in bit 6. A message-available flag is set by a pulse from the output queue and cleared by reset or by a clear-status pulse.

The request flag is a three-state machine. In ARMED, a high summary moves it to PENDING (the request is set). In PENDING, a poll moves it to SERVED if the summary is still high, or to ARMED if it is low. In SERVED, the summary going low moves it back to ARMED. From any state, a mask write that enables no summary source moves it to ARMED. The read path is a second state register. Its states are RB_NONE, RB_MASK, RB_STATUS and RB_POLL, and it holds the kind of response in flight. On each cycle it moves to whichever request has the highest priority.

Top module: `srq_status_top`

## Requirements
- R1: Status byte layout: bit 7 operation summary, bit 6 summary or request, bit 5 event summary, bit 4 message available, bit 3 questionable summary. Bits 2..0 always read 0.
- R2: A mask write stores all 8 bits of `mask_wdata_i` on the clock edge. A mask read returns the stored value on `rd_data_o` one cycle later, with `rd_valid_o` high. The mask resets to 0.
- R3: `mss_o` is, in the same cycle, the OR of status bits 7, 5, 4 and 3, each ANDed with its mask bit. Mask bit 6 is ignored.
- R4: A direct status read returns the byte with bit 6 equal to `mss_o` in the request cycle. It does not change `rqs_o`.
- R5: A serial poll returns the byte with bit 6 equal to `rqs_o` in the request cycle, clears `rqs_o` on that edge, and leaves `mss_o` unchanged.
- R6: `rqs_o` is set one cycle after `mss_o` goes high while ARMED. It stays set if `mss_o` falls. After a poll with `mss_o` still high it stays clear until `mss_o` falls and rises again.
- R7: `srq_o` is high exactly when `rqs_o` is high.
- R8: When the mask has no bit set other than bit 6, `srq_o` never asserts. Writing such a mask clears a pending request on that edge.
- R9: Message available (bit 4) is set by a `msg_avail_set_i` pulse and cleared by reset or `clr_status_i`. When both pulses arrive in the same cycle, the clear wins.
- R10: Read priority is poll, then status read, then mask read. Each request cycle yields exactly one response, one cycle later. `rd_valid_o` is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oper_sum_i | input | 1 | Operation status summary flag |
| esb_sum_i | input | 1 | Event status summary flag |
| ques_sum_i | input | 1 | Questionable status summary flag |
| msg_avail_set_i | input | 1 | Pulse: output queue holds a message |
| clr_status_i | input | 1 | Pulse: clear status (clears message available) |
| mask_wr_i | input | 1 | Write enable mask |
| mask_wdata_i | input | 8 | Enable mask write data |
| mask_rd_i | input | 1 | Read enable mask |
| stb_rd_i | input | 1 | Direct status byte read |
| poll_i | input | 1 | Serial poll strobe |
| rd_valid_o | output | 1 | Response valid |
| rd_data_o | output | 8 | Response data |
| mss_o | output | 1 | Live master summary |
| rqs_o | output | 1 | Latched request for service |
| srq_o | output | 1 | Service request line |

## Verification
A request machine stuck in the wrong state shows up at `srq_o`. It either misses the rise one cycle after `mss_o` goes high, or it comes back immediately after a poll while the summary is still high. A bad mask or message-available register changes `mss_o` in the same cycle, and changes bit 6 of the next direct read. A wrong priority or a swapped bit 6 in the read path appears in the response one cycle after the request. The scoreboard compares that response against the value the bench expects.

// File: rtl/srq_pkg.sv
package srq_pkg;
    localparam int SB_W     = 8;
    localparam int BIT_OPER = 7;
    localparam int BIT_MSS  = 6;
    localparam int BIT_ESB  = 5;
    localparam int BIT_MAV  = 4;
    localparam int BIT_QUES = 3;

    typedef enum logic [1:0] {
        REQ_ARMED   = 2'd0,
        REQ_PENDING = 2'd1,
        REQ_SERVED  = 2'd2
    } req_state_t;

    typedef enum logic [1:0] {
        RB_NONE   = 2'd0,
        RB_MASK   = 2'd1,
        RB_STATUS = 2'd2,
        RB_POLL   = 2'd3
    } rb_state_t;
endpackage

// File: rtl/srq_status_core.sv
module srq_status_core
    import srq_pkg::*;
#(
    parameter int W = SB_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         oper_i,
    input  logic         esb_i,
    input  logic         ques_i,
    input  logic         mav_set_i,
    input  logic         cls_i,
    input  logic         mask_wr_i,
    input  logic [W-1:0] mask_wdata_i,
    output logic [W-1:0] mask_q_o,
    output logic [W-1:0] status_o,
    output logic         mss_o,
    output logic         mask_off_wr_o
);
    localparam logic [W-1:0] ONE       = W'(1);
    localparam logic [W-1:0] SELF_MASK = ~(ONE << BIT_MSS);

    logic [W-1:0] mask_q;
    logic         mav_q;
    logic [W-1:0] cause;
    logic         mss;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (mask_wr_i) begin
            mask_q <= mask_wdata_i;
        end
    end

    // Clear wins over set (R9)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mav_q <= 1'b0;
        end else if (cls_i) begin
            mav_q <= 1'b0;
        end else if (mav_set_i) begin
            mav_q <= 1'b1;
        end
    end

    always_comb begin
        cause           = '0;
        cause[BIT_OPER] = oper_i;
        cause[BIT_ESB]  = esb_i;
        cause[BIT_MAV]  = mav_q;
        cause[BIT_QUES] = ques_i;
    end

    assign mss           = |(cause & mask_q & SELF_MASK);
    assign mss_o         = mss;
    assign status_o      = cause | (W'(mss) << BIT_MSS);
    assign mask_q_o      = mask_q;
    assign mask_off_wr_o = mask_wr_i && ((mask_wdata_i & SELF_MASK) == '0);
endmodule

// File: rtl/srq_req_fsm.sv
module srq_req_fsm
    import srq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mss_i,
    input  logic poll_i,
    input  logic mask_off_wr_i,
    output logic rqs_o
);
    req_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (mask_off_wr_i) begin
            state_d = REQ_ARMED;
        end else begin
            unique case (state_q)
                REQ_ARMED:   if (mss_i) state_d = REQ_PENDING;
                REQ_PENDING: if (poll_i) state_d = mss_i ? REQ_SERVED : REQ_ARMED;
                REQ_SERVED:  if (!mss_i) state_d = REQ_ARMED;
                default:     state_d = REQ_ARMED;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= REQ_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            REQ_PENDING: rqs_o = 1'b1;
            default:     rqs_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/srq_readback.sv
module srq_readback
    import srq_pkg::*;
#(
    parameter int W = SB_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         poll_i,
    input  logic         stb_rd_i,
    input  logic         mask_rd_i,
    input  logic [W-1:0] status_i,
    input  logic         rqs_i,
    input  logic [W-1:0] mask_i,
    output logic         rd_valid_o,
    output logic [W-1:0] rd_data_o
);
    rb_state_t    state_q, state_d;
    logic [W-1:0] data_q, data_d;
    logic [W-1:0] poll_byte;

    always_comb begin
        poll_byte          = status_i;
        poll_byte[BIT_MSS] = rqs_i;
    end

    always_comb begin
        if (poll_i) begin
            state_d = RB_POLL;
            data_d  = poll_byte;
        end else if (stb_rd_i) begin
            state_d = RB_STATUS;
            data_d  = status_i;
        end else if (mask_rd_i) begin
            state_d = RB_MASK;
            data_d  = mask_i;
        end else begin
            state_d = RB_NONE;
            data_d  = data_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RB_NONE;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            data_q  <= data_d;
        end
    end

    always_comb begin
        unique case (state_q)
            RB_NONE: rd_valid_o = 1'b0;
            default: rd_valid_o = 1'b1;
        endcase
        rd_data_o = data_q;
    end
endmodule

// File: rtl/srq_status_top.sv
module srq_status_top
    import srq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       oper_sum_i,
    input  logic       esb_sum_i,
    input  logic       ques_sum_i,
    input  logic       msg_avail_set_i,
    input  logic       clr_status_i,
    input  logic       mask_wr_i,
    input  logic [7:0] mask_wdata_i,
    input  logic       mask_rd_i,
    input  logic       stb_rd_i,
    input  logic       poll_i,
    output logic       rd_valid_o,
    output logic [7:0] rd_data_o,
    output logic       mss_o,
    output logic       rqs_o,
    output logic       srq_o
);
    logic [SB_W-1:0] mask_q;
    logic [SB_W-1:0] status_byte;
    logic            mss;
    logic            mask_off_wr;
    logic            rqs;

    srq_status_core #(.W(SB_W)) u_core (
        .clk           (clk),
        .rst_n         (rst_n),
        .oper_i        (oper_sum_i),
        .esb_i         (esb_sum_i),
        .ques_i        (ques_sum_i),
        .mav_set_i     (msg_avail_set_i),
        .cls_i         (clr_status_i),
        .mask_wr_i     (mask_wr_i),
        .mask_wdata_i  (mask_wdata_i),
        .mask_q_o      (mask_q),
        .status_o      (status_byte),
        .mss_o         (mss),
        .mask_off_wr_o (mask_off_wr)
    );

    srq_req_fsm u_req (
        .clk           (clk),
        .rst_n         (rst_n),
        .mss_i         (mss),
        .poll_i        (poll_i),
        .mask_off_wr_i (mask_off_wr),
        .rqs_o         (rqs)
    );

    srq_readback #(.W(SB_W)) u_rb (
        .clk        (clk),
        .rst_n      (rst_n),
        .poll_i     (poll_i),
        .stb_rd_i   (stb_rd_i),
        .mask_rd_i  (mask_rd_i),
        .status_i   (status_byte),
        .rqs_i      (rqs),
        .mask_i     (mask_q),
        .rd_valid_o (rd_valid_o),
        .rd_data_o  (rd_data_o)
    );

    assign mss_o = mss;
    assign rqs_o = rqs;
    assign srq_o = rqs;
endmodule

// File: rtl/srq_checker.sv
module srq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       poll_i,
    input logic       stb_rd_i,
    input logic       mask_rd_i,
    input logic       cls_i,
    input logic [7:0] mask_q,
    input logic [7:0] status_byte,
    input logic       mss_o,
    input logic       rqs_o,
    input logic       srq_o,
    input logic       rd_valid_o,
    input logic [7:0] rd_data_o
);
    assert_low_bits_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(poll_i || stb_rd_i) |-> (rd_data_o[2:0] == 3'b000));

    assert_mask_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mask_rd_i && !poll_i && !stb_rd_i) |-> (rd_data_o == $past(mask_q)));

    assert_direct_bit6_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stb_rd_i && !poll_i) |-> (rd_data_o[6] == $past(mss_o)));

    assert_poll_bit6_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(poll_i) |-> (rd_valid_o && (rd_data_o[6] == $past(rqs_o))));

    assert_poll_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rqs_o && poll_i) |=> !rqs_o);

    assert_rqs_needs_mss_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rqs_o) |-> $past(mss_o));

    assert_mask_off_no_srq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((mask_q & 8'hBF) == 8'h00) |-> !srq_o);

    assert_cls_clears_mav_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cls_i) |-> !status_byte[4]);

    assert_no_spurious_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> $past(poll_i || stb_rd_i || mask_rd_i));
endmodule

bind srq_status_top srq_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .poll_i      (poll_i),
    .stb_rd_i    (stb_rd_i),
    .mask_rd_i   (mask_rd_i),
    .cls_i       (clr_status_i),
    .mask_q      (mask_q),
    .status_byte (status_byte),
    .mss_o       (mss_o),
    .rqs_o       (rqs_o),
    .srq_o       (srq_o),
    .rd_valid_o  (rd_valid_o),
    .rd_data_o   (rd_data_o)
);

// File: tb/tb_srq_status_top.sv
`timescale 1ns/1ps
module tb_srq_status_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       oper_sum_i = 1'b0, esb_sum_i = 1'b0, ques_sum_i = 1'b0;
    logic       msg_avail_set_i = 1'b0, clr_status_i = 1'b0;
    logic       mask_wr_i = 1'b0;
    logic [7:0] mask_wdata_i = 8'h00;
    logic       mask_rd_i = 1'b0, stb_rd_i = 1'b0, poll_i = 1'b0;
    logic       rd_valid_o;
    logic [7:0] rd_data_o;
    logic       mss_o, rqs_o, srq_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    srq_status_top dut (
        .clk(clk), .rst_n(rst_n),
        .oper_sum_i(oper_sum_i), .esb_sum_i(esb_sum_i), .ques_sum_i(ques_sum_i),
        .msg_avail_set_i(msg_avail_set_i), .clr_status_i(clr_status_i),
        .mask_wr_i(mask_wr_i), .mask_wdata_i(mask_wdata_i),
        .mask_rd_i(mask_rd_i), .stb_rd_i(stb_rd_i), .poll_i(poll_i),
        .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
        .mss_o(mss_o), .rqs_o(rqs_o), .srq_o(srq_o)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic at_neg();
        @(negedge clk);
    endtask

    // Driver: issue a read request and push the expected response
    task automatic rd_op(input logic p, input logic s, input logic m,
                         input logic [7:0] exp, input string tag);
        poll_i = p; stb_rd_i = s; mask_rd_i = m;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        tick();
        poll_i = 1'b0; stb_rd_i = 1'b0; mask_rd_i = 1'b0;
    endtask

    task automatic wr_mask(input logic [7:0] v);
        mask_wr_i = 1'b1; mask_wdata_i = v;
        tick();
        mask_wr_i = 1'b0;
    endtask

    // Monitor: pop and compare each response
    always @(negedge clk) begin
        if (rst_n && rd_valid_o) begin
            if (exp_q.size() == 0) begin
                checks++; failures++;
                $display("FAIL R10 unexpected response actual=%h expected=none", rd_data_o);
            end else begin
                check(rd_data_o, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        at_neg();
        check({5'b0, mss_o, rqs_o, srq_o}, 8'h00, "R7 reset outputs");
        check({7'b0, rd_valid_o}, 8'h00, "R10 reset valid");
        tick();
        rd_op(0, 0, 1, 8'h00, "R2 mask reset value");
        wr_mask(8'hB8);
        rd_op(0, 0, 1, 8'hB8, "R2 mask readback");

        // Rising summary sets the request
        oper_sum_i = 1'b1;
        at_neg();
        check({7'b0, mss_o}, 8'h01, "R3 summary same cycle");
        check({7'b0, rqs_o}, 8'h00, "R6 request not yet set");
        tick(); at_neg();
        check({7'b0, rqs_o}, 8'h01, "R6 request set");
        check({7'b0, srq_o}, 8'h01, "R7 service line follows request");

        rd_op(0, 1, 0, 8'hC0, "R4 direct read bit6 is summary");
        at_neg();
        check({7'b0, rqs_o}, 8'h01, "R4 direct read leaves request");

        rd_op(1, 0, 0, 8'hC0, "R5 poll returns request");
        at_neg();
        check({6'b0, mss_o, rqs_o}, 8'h02, "R5 poll clears request keeps summary");
        repeat (3) tick();
        at_neg();
        check({7'b0, rqs_o}, 8'h00, "R6 no re-set while summary stays high");
        rd_op(1, 0, 0, 8'h80, "R5 poll after clear");

        // Fall then rise re-arms
        oper_sum_i = 1'b0;
        at_neg();
        check({7'b0, mss_o}, 8'h00, "R3 summary clears same cycle");
        tick();
        ques_sum_i = 1'b1;
        tick(); at_neg();
        check({7'b0, rqs_o}, 8'h01, "R6 re-armed after fall");
        rd_op(0, 1, 0, 8'h48, "R1 questionable in bit 3");

        // Mask with only bit 6 is effectively off
        wr_mask(8'h40);
        at_neg();
        check({7'b0, srq_o}, 8'h00, "R8 off mask clears pending request");
        oper_sum_i = 1'b1; esb_sum_i = 1'b1;
        msg_avail_set_i = 1'b1; tick(); msg_avail_set_i = 1'b0;
        repeat (3) tick();
        at_neg();
        check({6'b0, mss_o, srq_o}, 8'h00, "R8 R3 mask bit 6 ignored, no service line");
        rd_op(0, 1, 0, 8'hB8, "R1 full layout low bits zero");
        rd_op(0, 0, 1, 8'h40, "R2 mask readback bit 6");

        // Message available
        clr_status_i = 1'b1; tick(); clr_status_i = 1'b0;
        rd_op(0, 1, 0, 8'hA8, "R9 clear status clears message bit");
        msg_avail_set_i = 1'b1; clr_status_i = 1'b1; tick();
        msg_avail_set_i = 1'b0; clr_status_i = 1'b0;
        rd_op(0, 1, 0, 8'hA8, "R9 clear wins over set");
        msg_avail_set_i = 1'b1; tick(); msg_avail_set_i = 1'b0;
        rd_op(0, 1, 0, 8'hB8, "R9 set message bit");

        // Summary from message bit alone
        wr_mask(8'h10);
        at_neg();
        check({7'b0, mss_o}, 8'h01, "R3 message bit enabled");
        tick(); at_neg();
        check({7'b0, rqs_o}, 8'h01, "R6 request from message bit");
        clr_status_i = 1'b1; tick(); clr_status_i = 1'b0;
        at_neg();
        check({6'b0, mss_o, rqs_o}, 8'h01, "R6 request latched after summary falls");
        rd_op(1, 0, 0, 8'hE8, "R5 poll with latched request");

        // Priority
        msg_avail_set_i = 1'b1; tick(); msg_avail_set_i = 1'b0;
        tick(); at_neg();
        check({7'b0, rqs_o}, 8'h01, "R6 request before priority test");
        rd_op(0, 1, 1, 8'hF8, "R10 status read over mask read");
        rd_op(1, 1, 1, 8'hF8, "R10 poll over both");
        rd_op(1, 1, 0, 8'hB8, "R10 poll over status read");
        repeat (3) tick();
        check(8'(exp_q.size()), 8'h00, "R10 all responses received");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule